// File: doc/BRIEF.md
# Interleaved Delay-Line Strobe Sequencer

This block drives the switches of a nine-channel delay-and-sum receive beamformer in which every channel stores its input on an eight-cell analog delay line. The cells are used in rotation, one per sample period. A single rotating write index selects the cell that is being sampled. All channels share that index. Each channel then reads one of its own cells back, chosen as the write index minus that channel's delay code. The result is a fixed delay of between one and eight sample periods per channel. The block is clocked from a fast clock. The sample period is a parameter number of fast cycles long and is split into a readout window, a sampling window and a one-cycle gap.

Delay codes are written through a four-wire serial port into a shadow register. They reach the live registers only when a load request has been seen and the rotation passes from its last cell back to cell 0. Because of this, a delay set never changes part way through a rotation. When a conversion finishes, the block returns a one-cycle pulse that clears the summing node. Readouts are held off while that pulse is high.

Top module: `bf_strobe_seq`

## Requirements
- R1: While rst_ni is low, samp_o, rd_o and sum_rst_o are all zero, the write index is 0 and all live delay codes are 0.
- R2: The write index advances by one at the end of every DIV-cycle sample period and wraps from 7 to 0. In the first DIV/2 cycles of a period samp_o is zero. In the next cycles, up to and including cycle DIV-2, exactly bit [write index] of samp_o is high. In the last cycle of the period samp_o is zero, so no two sampling strobes are ever high together.
- R3: Channel k's readout strobes sit in rd_o[8k+7:8k]. In the first DIV/2 cycles of a period, exactly bit (write index − code_k) mod 8 of that group is high, and the group is zero in the other cycles.
- R4: Code d in 1..7 reads each cell d periods after it was sampled, and code 0 reads it 8 periods later. From the last cycle of a cell's sampling strobe to the last cycle of its readout strobe is d·DIV − (DIV − DIV/2 − 1) fast cycles. A channel's readout strobe and a sampling strobe are never high on the same cell in the same cycle.
- R5: rd_o stays zero for the first eight sample periods after reset, until every cell has been sampled once.
- R6: With cs_ni low, each rising edge of sclk_i shifts mosi_i into bit 0 of a 27-bit shadow register. Channel k's code is in shadow bits [3k+2:3k], so the word is sent MSB first and channel 8's code comes first.
- R7: Edges on sclk_i while cs_ni is high leave the shadow register unchanged.
- R8: A one-cycle load_i pulse sets a pending request. At the next transition of the write index from 7 to 0, the live codes take the shadow value. Readouts before that transition use the old codes.
- R9: sum_rst_o is high in exactly the cycle after each cycle in which conv_done_i is high, and rd_o is zero whenever sum_rst_o is high.
- R10: Writing the shadow register without a load request never changes the readout pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial port clock, sampled through a synchronizer |
| cs_ni | input | 1 | Serial port select, active low |
| mosi_i | input | 1 | Serial port data in |
| load_i | input | 1 | Request to move shadow codes to live registers at next wrap |
| conv_done_i | input | 1 | Conversion complete |
| samp_o | output | N_CELL | One-hot sampling strobes shared by all channels |
| rd_o | output | N_CH*N_CELL | Per-channel one-hot readout strobes, channel k at bits [8k+7:8k] |
| sum_rst_o | output | 1 | Summing-node reset pulse |

## Verification
The bench keeps the full nine-channel, eight-cell geometry and the two-stage serial synchronizer, but builds the block with DIV = 6. A whole rotation then takes only 48 fast cycles. This lets the bench reach the priming interval after reset, the boundary at which a load request takes effect, and the full eight-period delay of code 0 many times within a short run. With DIV = 6 the readout, sampling and gap windows are three, two and one cycles long, so a strobe placed one cycle off shows up at the outputs straight away.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    PH_READ   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_GAP    = 2'd2
  } phase_e;
endpackage

// File: rtl/bss_timebase.sv
module bss_timebase
  import bss_pkg::*;
#(
  parameter int DIV    = 10,
  parameter int N_CELL = 8,
  localparam int DW    = $clog2(DIV),
  localparam int IW    = $clog2(N_CELL),
  localparam int HALF  = DIV / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output phase_e        phase_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          wrap_o,
  output logic          primed_o
);
  logic [DW-1:0] div_q;
  logic [IW-1:0] wr_q;
  logic          primed_q;
  logic          tick;

  assign tick   = (div_q == DW'(DIV - 1));
  assign wrap_o = tick && (wr_q == IW'(N_CELL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      wr_q     <= '0;
      primed_q <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) wr_q <= wr_q + 1'b1;
      if (wrap_o) primed_q <= 1'b1;
    end
  end

  always_comb begin
    if (div_q < DW'(HALF))          phase_o = PH_READ;
    else if (div_q == DW'(DIV - 1)) phase_o = PH_GAP;
    else                            phase_o = PH_SAMPLE;
  end

  assign wr_idx_o = wr_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/bss_delay_regs.sv
module bss_delay_regs #(
  parameter int N_CH  = 9,
  parameter int IW    = 3,
  parameter int SYNC  = 2,
  localparam int SW   = N_CH * IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  input  logic          load_i,
  input  logic          wrap_i,
  output logic [SW-1:0] act_o
);
  logic [SYNC-1:0] sclk_s, cs_s, mosi_s;
  logic            sclk_d;
  logic            shift_en;
  logic [SW-1:0]   shadow_q, act_q;
  logic            pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[SYNC-2:0], sclk_i};
      cs_s   <= {cs_s[SYNC-2:0], cs_ni};
      mosi_s <= {mosi_s[SYNC-2:0], mosi_i};
      sclk_d <= sclk_s[SYNC-1];
    end
  end

  assign shift_en = sclk_s[SYNC-1] && !sclk_d && !cs_s[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (shift_en) shadow_q <= {shadow_q[SW-2:0], mosi_s[SYNC-1]};
      if (wrap_i) begin
        if (pend_q || load_i) act_q <= shadow_q;
        pend_q <= 1'b0;
      end else if (load_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/bss_read_map.sv
module bss_read_map #(
  parameter int N_CH   = 9,
  parameter int N_CELL = 8,
  localparam int IW    = $clog2(N_CELL)
) (
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [N_CH*IW-1:0]     act_i,
  input  logic                   en_i,
  output logic [N_CH*N_CELL-1:0] rd_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [IW-1:0] idx;
    // modulo wrap maps code 0 onto a full rotation
    assign idx = wr_idx_i - act_i[k*IW +: IW];
    assign rd_o[k*N_CELL +: N_CELL] = en_i ? (N_CELL'(1) << idx) : '0;
  end
endmodule

// File: rtl/bf_strobe_seq.sv
module bf_strobe_seq
  import bss_pkg::*;
#(
  parameter int N_CH   = 9,
  parameter int N_CELL = 8,
  parameter int DIV    = 10,
  parameter int SYNC   = 2,
  localparam int IW    = $clog2(N_CELL)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   cs_ni,
  input  logic                   mosi_i,
  input  logic                   load_i,
  input  logic                   conv_done_i,
  output logic [N_CELL-1:0]      samp_o,
  output logic [N_CH*N_CELL-1:0] rd_o,
  output logic                   sum_rst_o
);
  phase_e             phase;
  logic [IW-1:0]      wr_idx;
  logic               wrap, primed;
  logic [N_CH*IW-1:0] act;
  logic               sum_rst_q;
  logic               rd_en;

  bss_timebase #(.DIV(DIV), .N_CELL(N_CELL)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_o  (phase),
    .wr_idx_o (wr_idx),
    .wrap_o   (wrap),
    .primed_o (primed)
  );

  bss_delay_regs #(.N_CH(N_CH), .IW(IW), .SYNC(SYNC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .cs_ni  (cs_ni),
    .mosi_i (mosi_i),
    .load_i (load_i),
    .wrap_i (wrap),
    .act_o  (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_rst_q <= 1'b0;
    else         sum_rst_q <= conv_done_i;
  end

  assign rd_en = primed && (phase == PH_READ) && !sum_rst_q;

  bss_read_map #(.N_CH(N_CH), .N_CELL(N_CELL)) u_map (
    .wr_idx_i (wr_idx),
    .act_i    (act),
    .en_i     (rd_en),
    .rd_o     (rd_o)
  );

  assign samp_o    = (phase == PH_SAMPLE) ? (N_CELL'(1) << wr_idx) : '0;
  assign sum_rst_o = sum_rst_q;
endmodule

// File: rtl/bss_chk.sv
module bss_chk #(
  parameter int N_CH   = 9,
  parameter int N_CELL = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   conv_done_i,
  input logic [N_CELL-1:0]      samp_o,
  input logic [N_CH*N_CELL-1:0] rd_o,
  input logic                   sum_rst_o
);
  // R2
  samp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(samp_o));

  // R9
  sum_rst_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> sum_rst_o);

  // R9
  sum_rst_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> !sum_rst_o);

  // R9
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_rst_o |-> (rd_o == '0));

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    // R3
    rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rd_o[k*N_CELL +: N_CELL]));

    // R4
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_o[k*N_CELL +: N_CELL] & samp_o) == '0);
  end
endmodule

bind bf_strobe_seq bss_chk #(.N_CH(N_CH), .N_CELL(N_CELL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_done_i (conv_done_i),
  .samp_o      (samp_o),
  .rd_o        (rd_o),
  .sum_rst_o   (sum_rst_o)
);

// File: tb/bf_strobe_seq_tb.sv
`timescale 1ns/1ps
module bf_strobe_seq_tb;
  localparam int N_CH = 9, N_CELL = 8, DIV = 6, HALF = DIV / 2, SW = 27;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic rst_ni = 1'b0, sclk_i = 1'b0, cs_ni = 1'b1, mosi_i = 1'b0;
  logic load_i = 1'b0, conv_done_i = 1'b0;
  logic [N_CELL-1:0]      samp_o;
  logic [N_CH*N_CELL-1:0] rd_o;
  logic                   sum_rst_o;

  bf_strobe_seq #(.N_CH(N_CH), .N_CELL(N_CELL), .DIV(DIV), .SYNC(2)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni), .mosi_i(mosi_i),
    .load_i(load_i), .conv_done_i(conv_done_i), .samp_o(samp_o), .rd_o(rd_o),
    .sum_rst_o(sum_rst_o)
  );

  int errs = 0, checks = 0, n = 0, wd = 0;
  logic [SW-1:0] m_act = '0, m_shadow = '0;
  logic m_pend = 1'b0, m_rs = 1'b0;
  bit mon_en = 0;
  string tag = "R1";

  // reference model of period count, live codes and reset pulse
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      n = 0; m_act = '0; m_pend = 1'b0; m_rs = 1'b0;
    end else begin
      if ((n % DIV) == DIV - 1 && ((n / DIV) % 8) == 7) begin
        if (m_pend || load_i) m_act = m_shadow;
        m_pend = 1'b0;
      end else if (load_i) begin
        m_pend = 1'b1;
      end
      m_rs = conv_done_i;
      n = n + 1;
    end
  end

  task automatic chk(input bit ok, input string t, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h (n=%0d)", t, act, exp, n);
    end
  endtask

  always @(negedge clk_i) begin
    if (mon_en) begin
      logic [N_CELL-1:0] es;
      logic [71:0] er;
      int ph, p, wr;
      ph = n % DIV; p = n / DIV; wr = p % 8;
      es = '0; er = '0;
      if (ph >= HALF && ph <= DIV - 2) es[wr] = 1'b1;
      if (p >= 8 && ph < HALF && !m_rs)
        for (int k = 0; k < N_CH; k++) begin
          int code, eff;
          code = int'(m_act[3*k +: 3]);
          eff  = (code == 0) ? 8 : code;
          er[k*8 + ((wr - eff + 8) % 8)] = 1'b1;
        end
      chk(samp_o == es, {tag, " samp_o"}, 72'(samp_o), 72'(es));
      chk(rd_o == er, {tag, " rd_o"}, rd_o, er);
      chk(sum_rst_o == m_rs, {tag, " sum_rst_o"}, 72'(sum_rst_o), 72'(m_rs));
    end
  end

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk_i);
  endtask

  task automatic spi_write(input logic [SW-1:0] w);
    cs_ni = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      mosi_i = w[i];
      wait_cyc(3); sclk_i = 1'b1;
      wait_cyc(3); sclk_i = 1'b0;
    end
    wait_cyc(3); cs_ni = 1'b1;
    wait_cyc(4);
  endtask

  task automatic pulse_load();
    load_i = 1'b1; @(negedge clk_i); load_i = 1'b0;
  endtask

  task automatic goto_cell(input int c);
    while (((n / DIV) % 8) != c || (n % DIV) != 0) @(negedge clk_i);
  endtask

  // R1
  task automatic t_reset();
    rst_ni = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(samp_o == '0 && rd_o == '0 && sum_rst_o == 1'b0, "R1 reset outputs",
          {samp_o, rd_o[63:0]}, 72'h0);
    end
    rst_ni = 1'b1;
    mon_en = 1;
  endtask

  // R5 then R2 R3 with all codes 0 (full rotation delay)
  task automatic t_startup();
    tag = "R5"; wait_cyc(8 * DIV);
    tag = "R2 R3"; wait_cyc(2 * 8 * DIV);
  endtask

  // R6 R8: ch k gets code k mod 8, loaded mid-rotation
  task automatic t_spi_load();
    logic [SW-1:0] w;
    for (int k = 0; k < N_CH; k++) w[3*k +: 3] = 3'(k % 8);
    tag = "R6";
    spi_write(w);
    m_shadow = w;
    goto_cell(2);
    tag = "R8";
    pulse_load();
    wait_cyc(2 * 8 * DIV);
  endtask

  // R4: cell 2 sample end to read end
  task automatic t_measure(input int ch, input int d);
    int t0, t1, exp_c;
    tag = "R4";
    while (!samp_o[2]) @(negedge clk_i);
    while (samp_o[2]) @(negedge clk_i);
    t0 = n - 1;
    while (!rd_o[ch*8 + 2]) @(negedge clk_i);
    while (rd_o[ch*8 + 2]) @(negedge clk_i);
    t1 = n - 1;
    exp_c = d * DIV - (DIV - HALF - 1);
    chk((t1 - t0) == exp_c, $sformatf("R4 delay ch%0d", ch), 72'(t1 - t0), 72'(exp_c));
  endtask

  // R7: clocking with cs high must not alter shadow
  task automatic t_ignore();
    tag = "R7";
    mosi_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wait_cyc(3); sclk_i = 1'b1;
      wait_cyc(3); sclk_i = 1'b0;
    end
    wait_cyc(4);
    pulse_load();
    wait_cyc(2 * 8 * DIV);
  endtask

  // R10 then R8 apply
  task automatic t_noload();
    tag = "R10";
    spi_write({SW{1'b1}});
    m_shadow = {SW{1'b1}};
    wait_cyc(2 * 8 * DIV);
    tag = "R8";
    goto_cell(5);
    pulse_load();
    wait_cyc(2 * 8 * DIV);
  endtask

  // R9
  task automatic t_conv();
    tag = "R9";
    goto_cell(3);
    conv_done_i = 1'b1; @(negedge clk_i); conv_done_i = 1'b0;
    chk(sum_rst_o == 1'b1 && rd_o == '0, "R9 pulse blocks readout", {7'h0, sum_rst_o, rd_o[63:0]},
        {8'h01, 64'h0});
    @(negedge clk_i);
    chk(sum_rst_o == 1'b0, "R9 pulse one cycle", 72'(sum_rst_o), 72'h0);
    goto_cell(4);
    conv_done_i = 1'b1; wait_cyc(2); conv_done_i = 1'b0;
    chk(sum_rst_o == 1'b1, "R9 back-to-back", 72'(sum_rst_o), 72'h1);
    @(negedge clk_i);
    chk(sum_rst_o == 1'b0, "R9 back-to-back end", 72'(sum_rst_o), 72'h0);
    wait_cyc(8 * DIV);
  endtask

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", wd);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_startup();
    t_spi_load();
    t_measure(3, 3);
    t_measure(0, 8);
    t_ignore();
    t_noload();
    t_measure(5, 7);
    t_conv();
    mon_en = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule